// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment Converter

This block is a purely combinational 16-bit adder. It takes two operands and a carry input and returns a 16-bit sum and a carry output. Inside, the word is cut into five groups whose widths grow toward the most significant end: 2, 2, 3, 4 and 5 bits, starting from bit 0. Because of this growth, the carry chain inside each group takes about as long as the carry-select path that arrives from the groups below.

The lowest group adds directly with the external carry input. Each higher group has only one sub-adder, and its carry-in is tied to zero. An increment converter turns that group's zero-carry result into its carry-one result. The converter works on the group sum together with its carry bit. A 2:1 multiplexer then picks one of the two results, using the carry-out of the group just below as the select.

A build-time parameter chooses the form of the zero-carry sub-adder. It can be a plain ripple chain, or a ripple chain with a group-propagate bypass (carry-skip). The converter and multiplexer structure is the same in both forms.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every input, {cout_o, sum_o} equals the 17-bit value a_i + b_i + cin_i.
- R2: 0xAABF + 0x03FA gives sum 0xAEB9 and cout 0 when cin is 0, and sum 0xAEBA and cout 0 when cin is 1.
- R3: Group boundaries sit between bits 1|2, 3|4, 6|7 and 10|11. A carry formed below any boundary reaches the bits above it. For example, (2^k − 1) + 1 gives 2^k for k = 2, 4, 7 and 11.
- R4: The increment converter of a group with w bits maps its (w+1)-bit input, {zero-carry carry-out, zero-carry sum}, to that value plus one. Bit i of the output is bit i of the input XOR the AND of all input bits below i.
- R5: Each upper group outputs its zero-carry result when the carry from the group below is 0, and the converter result when that carry is 1. In both cases the group output equals the group's operands plus that incoming carry.
- R6: In the carry-skip form, a group whose bits all propagate (every a XOR b bit is 1) passes its carry-in straight to its carry-out. Both sub-adder forms give identical sum and cout for every input.
- R7: The lowest group uses cin_i directly: 0 + 0 + 1 gives sum 0x0001 and cout 0.
- R8: A carry propagates through the full word: 0xFFFF + 0x0000 + 1 and 0xFFFF + 0x0001 + 0 both give sum 0x0000 and cout 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
The hardest case to reach from the ports is an upper group whose multiplexer select is 1 while its own operands all propagate. Only in that case does the converter carry a 1 through every bit, and only then does the skip bypass decide the group carry-out. Uniform random operands rarely set up a full propagate in a 4- or 5-bit group at the same moment as an incoming carry. The stimulus therefore often sets b to the complement of a, then flips a few random bits, and mixes this with directed all-ones and boundary-crossing vectors. Both sub-adder forms run side by side on the same inputs.

// File: rtl/sqcs_pkg.sv
package sqcs_pkg;

  localparam int NGRP = 5;

  typedef enum logic {
    SUB_RIPPLE = 1'b0,
    SUB_SKIP   = 1'b1
  } sub_kind_e;

  // Width of group g, counted from the least significant end.
  function automatic int grp_w(input int g);
    case (g)
      0:       return 2;
      1:       return 2;
      2:       return 3;
      3:       return 4;
      default: return 5;
    endcase
  endfunction

  // Lowest bit position of group g.
  function automatic int grp_lo(input int g);
    int acc;
    acc = 0;
    for (int i = 0; i < g; i++) acc += grp_w(i);
    return acc;
  endfunction

  localparam int DATA_W = grp_lo(NGRP);

endpackage

// File: rtl/sqcs_subadd.sv
module sqcs_subadd #(
  parameter int                  W    = 4,
  parameter sqcs_pkg::sub_kind_e KIND = sqcs_pkg::SUB_RIPPLE
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  logic [W-1:0] prop;
  logic [W-1:0] gen;
  logic [W:0]   chain;
  logic         grp_prop;

  assign prop     = a ^ b;
  assign gen      = a & b;
  assign chain[0] = ci;
  assign grp_prop = &prop;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i]       = prop[i] ^ chain[i];
    assign chain[i+1] = gen[i] | (prop[i] & chain[i]);
  end

  if (KIND == sqcs_pkg::SUB_SKIP) begin : g_skip
    assign co = grp_prop ? ci : chain[W];
  end else begin : g_ripple
    assign co = chain[W];
  end

  always_comb begin
    // R6
    skip_pass_chk: assert (!grp_prop || co == ci)
      else $error("group propagate did not pass carry-in");
    // R1
    subadd_sum_chk: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci}))
      else $error("sub-adder result mismatch");
  end

endmodule

// File: rtl/sqcs_excess1.sv
module sqcs_excess1 #(
  parameter int W = 5
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);

  logic [W-1:0] run_and;

  assign run_and[0] = x[0];
  assign y[0]       = ~x[0];

  for (genvar i = 1; i < W; i++) begin : g_bit
    assign run_and[i] = run_and[i-1] & x[i];
    assign y[i]       = x[i] ^ run_and[i-1];
  end

  always_comb begin
    // R4
    excess_one_chk: assert (y == x + {{(W-1){1'b0}}, 1'b1})
      else $error("converter output is not input plus one");
  end

endmodule

// File: rtl/sqcs_group.sv
module sqcs_group #(
  parameter int                  W     = 4,
  parameter sqcs_pkg::sub_kind_e KIND  = sqcs_pkg::SUB_RIPPLE,
  parameter bit                  FIRST = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_ci,
  output logic [W-1:0] s,
  output logic         co
);

  if (FIRST) begin : g_first
    sqcs_subadd #(.W(W), .KIND(KIND)) u_add (
      .a(a), .b(b), .ci(sel_ci), .s(s), .co(co)
    );
  end else begin : g_upper
    logic [W-1:0] s_zero;
    logic         c_zero;
    logic [W:0]   res_zero;
    logic [W:0]   res_one;
    logic [W:0]   res_pick;

    sqcs_subadd #(.W(W), .KIND(KIND)) u_add (
      .a(a), .b(b), .ci(1'b0), .s(s_zero), .co(c_zero)
    );

    assign res_zero = {c_zero, s_zero};

    sqcs_excess1 #(.W(W + 1)) u_inc (
      .x(res_zero), .y(res_one)
    );

    assign res_pick = sel_ci ? res_one : res_zero;
    assign s        = res_pick[W-1:0];
    assign co       = res_pick[W];

    always_comb begin
      // R5
      grp_select_chk: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, sel_ci}))
        else $error("group select result mismatch");
    end
  end

endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder #(
  parameter sqcs_pkg::sub_kind_e SUB_KIND = sqcs_pkg::SUB_RIPPLE
) (
  input  logic [sqcs_pkg::DATA_W-1:0] a_i,
  input  logic [sqcs_pkg::DATA_W-1:0] b_i,
  input  logic                        cin_i,
  output logic [sqcs_pkg::DATA_W-1:0] sum_o,
  output logic                        cout_o
);

  localparam int NG = sqcs_pkg::NGRP;
  localparam int DW = sqcs_pkg::DATA_W;

  logic [NG:0] grp_carry;

  assign grp_carry[0] = cin_i;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int GW = sqcs_pkg::grp_w(g);
    localparam int LO = sqcs_pkg::grp_lo(g);

    sqcs_group #(
      .W    (GW),
      .KIND (SUB_KIND),
      .FIRST(g == 0)
    ) u_grp (
      .a     (a_i[LO +: GW]),
      .b     (b_i[LO +: GW]),
      .sel_ci(grp_carry[g]),
      .s     (sum_o[LO +: GW]),
      .co    (grp_carry[g+1])
    );
  end

  assign cout_o = grp_carry[NG];

  always_comb begin
    // R1
    word_sum_chk: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i}))
      else $error("word sum mismatch");
  end

endmodule

// File: tb/sqrt_csel_adder_bench.sv
module sqrt_csel_adder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a, b;
  logic        cin;
  logic [15:0] s_r, s_k;
  logic        co_r, co_k;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  sqrt_csel_adder #(.SUB_KIND(sqcs_pkg::SUB_RIPPLE)) u_sqrt_csel_adder (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s_r), .cout_o(co_r)
  );

  sqrt_csel_adder #(.SUB_KIND(sqcs_pkg::SUB_SKIP)) u_sqrt_csel_adder_skip (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s_k), .cout_o(co_k)
  );

  // Bitwise reference: majority carry and three-way XOR, bit by bit.
  function automatic logic [16:0] ref_add(input logic [15:0] x, input logic [15:0] y,
                                          input logic c);
    logic [16:0] r;
    logic        k;
    k = c;
    for (int i = 0; i < 16; i++) begin
      r[i] = x[i] ^ y[i] ^ k;
      k    = (x[i] & y[i]) | (x[i] & k) | (y[i] & k);
    end
    r[16] = k;
    return r;
  endfunction

  task automatic cmp(input string req, input string which, input logic [16:0] got,
                     input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: a=%h b=%h cin=%0d got %h expected %h",
               req, which, a, b, cin, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c,
                       input string req);
    logic [16:0] exp;
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    exp = ref_add(x, y, c);
    cmp(req, "ripple", {co_r, s_r}, exp);
    cmp(req, "skip", {co_k, s_k}, exp);
    // R6: both forms agree
    cmp("R6", "forms", {co_k, s_k}, {co_r, s_r});
  endtask

  task automatic expect_lit(input logic [16:0] exp, input string req);
    cmp(req, "ripple-lit", {co_r, s_r}, exp);
    cmp(req, "skip-lit", {co_k, s_k}, exp);
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: zero plus zero
    apply(16'h0000, 16'h0000, 1'b0, "R1");
    expect_lit(17'h00000, "R1");

    // R2 worked examples
    apply(16'hAABF, 16'h03FA, 1'b0, "R2");
    expect_lit({1'b0, 16'hAEB9}, "R2");
    apply(16'hAABF, 16'h03FA, 1'b1, "R2");
    expect_lit({1'b0, 16'hAEBA}, "R2");

    // R7 lowest group takes cin directly
    apply(16'h0000, 16'h0000, 1'b1, "R7");
    expect_lit(17'h00001, "R7");

    // R8 full-word propagate
    apply(16'hFFFF, 16'h0000, 1'b1, "R8");
    expect_lit(17'h10000, "R8");
    apply(16'hFFFF, 16'h0001, 1'b0, "R8");
    expect_lit(17'h10000, "R8");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R8");

    // R3 carry across each group boundary; R4/R5 converter selected
    apply(16'h0003, 16'h0001, 1'b0, "R3");
    expect_lit(17'h00004, "R3");
    apply(16'h000F, 16'h0001, 1'b0, "R3");
    expect_lit(17'h00010, "R3");
    apply(16'h007F, 16'h0001, 1'b0, "R3");
    expect_lit(17'h00080, "R3");
    apply(16'h07FF, 16'h0001, 1'b0, "R3");
    expect_lit(17'h00800, "R3");

    // Alternating patterns, R4 and R5 paths
    apply(16'hAAAA, 16'h5555, 1'b1, "R5");
    apply(16'h5555, 16'h5555, 1'b0, "R4");
    apply(16'hAAAA, 16'hAAAA, 1'b1, "R4");

    // Random: half with near-complement operands to build long propagates
    void'($urandom(32'h00C0FFEE));
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] x, y;
      logic        c;
      x = 16'($urandom);
      if ($urandom % 2 == 0) y = ~x ^ (16'h1 << ($urandom % 16));
      else                   y = 16'($urandom);
      c = 1'($urandom);
      apply(x, y, c, "R1");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule